// File: doc/BRIEF.md
# Write-Count-Unlocked Configuration Register Bank

This block holds a small bank of configuration words. A host writes it through a strobe-qualified address/data port. Each location has two stages. The first is a programming register that takes the written word. The second is an output register that drives the settings to the logic that uses them. The output stage is set to known values by reset. The programming stage is not reset and starts with whatever content it has at power-up.

A saturating counter counts strobed writes. Until that count reaches the unlock threshold (32 by default), the output stage stays frozen at its reset values. In the clock edge that takes the threshold write, every output field loads its programming register. This includes that last write. Any location never written by then shows its power-up content. From that point the gate stays open until reset, so each later write reaches the output in the edge that samples it.

Locations 13 and 14 have no storage and always read zero, but writes to them still count toward the threshold. Location 10 is reserved and behaves like any implemented location.

Top module: `wrlock_cfg_bank`

## Requirements
- R1: While and after reset, each implemented location's output field (`cfg_o[i*4 +: 4]` for location i) equals its `LATCH_INIT` field, and absent fields read zero.
- R2: Before the threshold write is sampled, strobed writes leave `cfg_o` unchanged.
- R3: At the clock edge that samples the 32nd strobed write since reset, every implemented field takes the latest content of its programming register, including the data of that 32nd write.
- R4: An implemented location never written before the unlock edge shows its power-up programming content (`PROG_PWRUP` field) after that edge.
- R5: After unlock, a strobed write to an implemented location appears in its output field at the edge that samples the strobe.
- R6: Locations 13 and 14 always read zero and keep no data. A write to them still counts toward the threshold and changes no output field.
- R7: Reserved location 10 stores and presents data like any implemented location.
- R8: The write count saturates at the threshold and the unlocked state holds until reset, so writes after any number of further writes still take effect at once.
- R9: A reset returns the output fields to `LATCH_INIT` and relocks the gate. Programming registers keep their contents through reset.
- R10: A cycle with `wr_stb` low neither counts as a write nor changes any register, whatever `wr_addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of counter and output stage |
| wr_stb | input | 1 | Write qualifier, sampled on the rising edge |
| wr_addr | input | 4 | Location written |
| wr_data | input | 4 | Word written |
| cfg_o | output | 64 | Output fields, location i at bits i*4+3 down to i*4 |

## Verification
Every result of this block is due one rising edge after the stimulus. A write sampled at an edge shows up at that edge when the gate is open or when it is the unlock write. Otherwise the write must leave `cfg_o` unchanged at that edge. The bench drives inputs on falling edges, holds the strobe for one full period and compares at the next falling edge, half a period after the edge that produced the result. Idle cycles carrying garbage address and data are placed between counted writes, so a miscounted write would move the unlock edge earlier and show up as a frozen-output failure.

// File: rtl/wlcb_pkg.sv
package wlcb_pkg;

    // Gate state of the output stage.
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

endpackage

// File: rtl/wlcb_wcount.sv
module wlcb_wcount
    import wlcb_pkg::*;
#(
    parameter int unsigned LIMIT = 32,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    output logic          open_d,
    output logic          open_q,
    output logic [CW-1:0] cnt_q
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        gate_e         gate;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Count only while shut, so the count saturates at LIMIT.
        if (wr_stb && st_q.gate == GATE_SHUT) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        if (st_d.cnt == CW'(LIMIT)) begin
            st_d.gate = GATE_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.gate <= GATE_SHUT;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_d = (st_d.gate == GATE_OPEN);
    assign open_q = (st_q.gate == GATE_OPEN);
    assign cnt_q  = st_q.cnt;

endmodule

// File: rtl/wlcb_progfile.sv
module wlcb_progfile #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 4,
    localparam int unsigned NUM_LOC = 1 << ADDR_W,
    localparam int unsigned FW = NUM_LOC * DATA_W,
    parameter logic [NUM_LOC-1:0] ABSENT_MASK = '0,
    parameter logic [FW-1:0] PROG_PWRUP = '0
) (
    input  logic              clk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FW-1:0]     prog_nxt
);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        if (ABSENT_MASK[g]) begin : g_absent
            assign prog_nxt[g*DATA_W +: DATA_W] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] r_d, r_q;

            // No reset: content is undefined at power-up; PROG_PWRUP
            // stands for that arbitrary content.
            initial r_q = PROG_PWRUP[g*DATA_W +: DATA_W];

            always_comb begin
                r_d = r_q;
                if (wr_stb && wr_addr == ADDR_W'(g)) begin
                    r_d = wr_data;
                end
            end

            always @(posedge clk) begin
                r_q <= r_d;
            end

            assign prog_nxt[g*DATA_W +: DATA_W] = r_d;
        end
    end

endmodule

// File: rtl/wlcb_latch.sv
module wlcb_latch #(
    parameter int unsigned NUM_LOC = 16,
    parameter int unsigned DATA_W  = 4,
    localparam int unsigned FW = NUM_LOC * DATA_W,
    parameter logic [NUM_LOC-1:0] ABSENT_MASK = '0,
    parameter logic [FW-1:0] LATCH_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_d,
    input  logic [FW-1:0] prog_nxt,
    output logic [FW-1:0] cfg_o
);

    function automatic logic [FW-1:0] keep_bits();
        logic [FW-1:0] k;
        k = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            k[i*DATA_W +: DATA_W] = ABSENT_MASK[i] ? '0 : {DATA_W{1'b1}};
        end
        return k;
    endfunction

    localparam logic [FW-1:0] KEEP = keep_bits();

    typedef struct packed {
        logic [FW-1:0] val;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Open (or opening this edge): follow the programming stage.
        if (open_d) begin
            st_d.val = prog_nxt & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= LATCH_INIT & KEEP;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.val;

endmodule

// File: rtl/wrlock_cfg_bank.sv
module wrlock_cfg_bank #(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 4,
    parameter int unsigned UNLOCK_WRITES = 32,
    localparam int unsigned NUM_LOC = 1 << ADDR_W,
    localparam int unsigned FW      = NUM_LOC * DATA_W,
    localparam int unsigned CW      = $clog2(UNLOCK_WRITES + 1),
    parameter logic [NUM_LOC-1:0] ABSENT_MASK = NUM_LOC'(16'h6000),
    parameter logic [FW-1:0] LATCH_INIT = '0,
    parameter logic [FW-1:0] PROG_PWRUP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FW-1:0]     cfg_o
);

    logic          open_d;
    logic          open_q;
    logic [CW-1:0] cnt_q;
    logic [FW-1:0] prog_nxt;

    wlcb_wcount #(
        .LIMIT (UNLOCK_WRITES)
    ) count_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .open_d (open_d),
        .open_q (open_q),
        .cnt_q  (cnt_q)
    );

    wlcb_progfile #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ABSENT_MASK (ABSENT_MASK),
        .PROG_PWRUP  (PROG_PWRUP)
    ) prog_i (
        .clk      (clk),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .prog_nxt (prog_nxt)
    );

    wlcb_latch #(
        .NUM_LOC     (NUM_LOC),
        .DATA_W      (DATA_W),
        .ABSENT_MASK (ABSENT_MASK),
        .LATCH_INIT  (LATCH_INIT)
    ) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_d   (open_d),
        .prog_nxt (prog_nxt),
        .cfg_o    (cfg_o)
    );

endmodule

// File: rtl/wlcb_chk.sv
module wlcb_chk #(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 4,
    parameter int unsigned UNLOCK_WRITES = 32,
    localparam int unsigned NUM_LOC = 1 << ADDR_W,
    localparam int unsigned FW      = NUM_LOC * DATA_W,
    localparam int unsigned CW      = $clog2(UNLOCK_WRITES + 1),
    parameter logic [NUM_LOC-1:0] ABSENT_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [FW-1:0]     cfg_o,
    input logic              open_d,
    input logic              open_q,
    input logic [CW-1:0]     cnt_q
);

    function automatic logic [FW-1:0] absent_bits();
        logic [FW-1:0] k;
        k = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            k[i*DATA_W +: DATA_W] = ABSENT_MASK[i] ? {DATA_W{1'b1}} : '0;
        end
        return k;
    endfunction

    localparam logic [FW-1:0] ABSENT_BITS = absent_bits();

    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk) begin
        a_q <= wr_addr;
        d_q <= wr_data;
    end

    // R2
    frozen_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_d |=> $stable(cfg_o));

    // R5
    write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && wr_stb && !ABSENT_MASK[wr_addr])
        |=> cfg_o[a_q*DATA_W +: DATA_W] == d_q);

    // R6
    absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o & ABSENT_BITS) == '0);

    // R8
    stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |=> open_q);

    // R8
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(UNLOCK_WRITES));

endmodule

bind wrlock_cfg_bank wlcb_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .UNLOCK_WRITES (UNLOCK_WRITES),
    .ABSENT_MASK   (ABSENT_MASK)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg_o),
    .open_d  (open_d),
    .open_q  (open_q),
    .cnt_q   (cnt_q)
);

// File: tb/wrlock_cfg_bank_tb_top.sv
module wrlock_cfg_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int DW = 4;
    localparam int FW = NL * DW;
    localparam int WRITES = 32;
    localparam logic [NL-1:0] ABSENT = 16'h6000;
    localparam logic [FW-1:0] INIT = 64'h9999_3C5A_A5C3_1E78;

    function automatic logic [FW-1:0] pwrup_fn(input logic [63:0] seed);
        logic [63:0] v;
        v = seed;
        for (int i = 0; i < 7; i++) begin
            v = v ^ (v << 13);
            v = v ^ (v >> 7);
            v = v ^ (v << 17);
        end
        if (v[23:20] == INIT[23:20]) v[20] = ~v[20];
        return v;
    endfunction

    localparam logic [FW-1:0] PWRUP = pwrup_fn(64'h0123_4567_89AB_CDEF);

    // {addr, data}; location 5 never written, absent 13/14 included.
    localparam logic [7:0] VEC [WRITES] = '{
        8'h03, 8'h18, 8'h2d, 8'h32, 8'h47, 8'hdc, 8'h61, 8'h76,
        8'h8b, 8'h90, 8'ha5, 8'hba, 8'hcf, 8'hd4, 8'he9, 8'hfe,
        8'h04, 8'h19, 8'h2e, 8'h33, 8'h48, 8'hdd, 8'h62, 8'h77,
        8'h8c, 8'h91, 8'ha6, 8'hbb, 8'hc0, 8'hd5, 8'hea, 8'hff
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic [FW-1:0] cfg_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] prog_m [NL];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wrlock_cfg_bank #(
        .ABSENT_MASK (ABSENT),
        .LATCH_INIT  (INIT),
        .PROG_PWRUP  (PWRUP)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg_o)
    );

    function automatic logic [FW-1:0] exp_init();
        logic [FW-1:0] e;
        for (int i = 0; i < NL; i++)
            e[i*DW +: DW] = ABSENT[i] ? '0 : INIT[i*DW +: DW];
        return e;
    endfunction

    function automatic logic [FW-1:0] exp_prog();
        logic [FW-1:0] e;
        for (int i = 0; i < NL; i++)
            e[i*DW +: DW] = ABSENT[i] ? '0 : prog_m[i];
        return e;
    endfunction

    task automatic check_vec(input string req, input logic [FW-1:0] exp);
        checks++;
        if (cfg_o !== exp) begin
            errors++;
            $display("FAIL %s: cfg_o=%h expected %h", req, cfg_o, exp);
        end
    endtask

    task automatic check_fld(input string req, input int loc, input logic [DW-1:0] exp);
        checks++;
        if (cfg_o[loc*DW +: DW] !== exp) begin
            errors++;
            $display("FAIL %s: field %0d=%h expected %h", req, loc, cfg_o[loc*DW +: DW], exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        if (!ABSENT[a]) prog_m[a] = d;
    endtask

    task automatic idle_junk(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_stb = 1'b0; wr_addr = a; wr_data = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) prog_m[i] = PWRUP[i*DW +: DW];
        repeat (3) @(negedge clk);
        // R1: reset values visible, R6 absent fields zero
        check_vec("R1", exp_init());
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 R6", exp_init());

        // Vector walk: frozen until the 32nd write, idle junk never counts
        for (int k = 0; k < WRITES; k++) begin
            do_write(VEC[k][7:4], VEC[k][3:0]);
            if (k < WRITES - 1) begin
                check_vec("R2 R10", exp_init());
                idle_junk(4'(k), ~VEC[k][3:0]);
                idle_junk(4'(k + 3), VEC[k][3:0]);
            end
        end
        // R3: unlock edge loads every implemented field, incl. last write
        check_vec("R3", exp_prog());
        // R4: never-written location shows its power-up content
        check_fld("R4", 5, PWRUP[5*DW +: DW]);
        // R7: reserved location holds its written value
        check_fld("R7", 10, 4'h6);
        // R6: absent fields zero despite counted writes
        check_fld("R6", 13, 4'h0);
        check_fld("R6", 14, 4'h0);

        // R5: immediate effect once unlocked
        do_write(4'd3, 4'h6);
        check_fld("R5", 3, 4'h6);
        do_write(4'd10, 4'hC);
        check_fld("R7", 10, 4'hC);
        // R10: strobe low after unlock changes nothing
        idle_junk(4'd3, 4'h1);
        idle_junk(4'd3, 4'h1);
        check_vec("R10", exp_prog());

        // R8: many further writes, gate still open
        for (int k = 0; k < 40; k++) do_write(4'(k % 13), 4'(k * 7));
        check_vec("R8", exp_prog());
        do_write(4'd0, 4'h9);
        check_fld("R8", 0, 4'h9);

        // R6: write to absent location changes no field
        do_write(4'd13, 4'hF);
        check_vec("R6", exp_prog());

        // R9: reset relocks, programming content survives
        do_reset();
        @(negedge clk);
        check_vec("R9", exp_init());
        for (int k = 0; k < WRITES - 1; k++) do_write(4'd14, 4'(k));
        check_vec("R9 R6", exp_init());
        do_write(4'd14, 4'h7);
        check_vec("R9", exp_prog());

        finish_run();
    end

endmodule